// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. Its clock runs at a fixed multiple of the bit rate (sixteen by default), so every serial bit occupies that many clocks. A host writes a character into a holding register with an active-low load strobe. When the serial engine is free, the character moves into a separate frame shifter. A second character may be written while the first is still on the line. It then follows the first with no idle time between the frames.

Each frame is a low start bit, then five to eight data bits sent least significant bit first, then an optional odd or even parity bit, then a high stop period of one, one and a half or two bit times. The format comes from a small control register. That register either follows its inputs or holds the value it had when its load input went low. The format is frozen for each character when that character enters the shifter. Two status outputs report an empty holding register and a fully idle transmitter. After master reset, the transmitter stays quiet for a fixed settling period.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst` is high, and for the first 17 clocks after it falls, `tx_empty` is low, `buf_empty` is high and `txd` is high. `tx_empty` goes high after the 18th rising clock edge with `rst` low. A character loaded during this time waits until the period has ended.
- R2: Data on `din` is written into the holding register while `load_n` is low. A low level alone leaves `buf_empty` unchanged. The clock edge that first samples `load_n` high after it was low makes `buf_empty` low.
- R3: With the shifter idle, the character moves to the shifter one clock after `buf_empty` falls. On that edge `buf_empty` returns high, `tx_empty` goes low and `txd` drives the start bit low. Every start, data and parity bit lasts exactly 16 clocks.
- R4: A frame is sent as a low start bit, then the data bits least significant bit first, then the parity bit if enabled, then the high stop period. When nothing is being sent, `txd` is high.
- R5: `len_sel` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `din` above the selected length are neither sent nor counted in the parity.
- R6: With `par_off` = 1, no parity bit is sent. With `par_off` = 0, a parity bit follows the data. If `par_even` = 1, the parity bit is the XOR of the data bits. If `par_even` = 0, it is the inverse of that XOR.
- R7: With `stop_sel` = 0, the stop period lasts 16 clocks. With `stop_sel` = 1 and a 5-bit length, it lasts 24 clocks. With `stop_sel` = 1 and any other length, it lasts 32 clocks.
- R8: A character loaded while a frame is in progress waits, and `buf_empty` stays low in the meantime. Its start bit begins on the clock right after the last stop clock of the current frame, and `buf_empty` goes high at that moment.
- R9: When no character is waiting, `tx_empty` goes high on the clock right after the last stop clock. `tx_empty` high always implies that `txd` is high.
- R10: While `cfg_load` is high, the control register takes the format inputs on every clock. While `cfg_load` is low, it keeps the last value it took. Each frame uses the control value present when its character enters the shifter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, 16 times the bit rate |
| rst | input | 1 | Master reset, active high |
| cfg_load | input | 1 | Control register follows the format inputs while high and holds while low |
| len_sel | input | 2 | Data length select: 0..3 selects 5..8 bits |
| stop_sel | input | 1 | Long stop period when high |
| par_off | input | 1 | Parity bit omitted when high |
| par_even | input | 1 | Even parity when high, odd when low |
| load_n | input | 1 | Active-low holding register load strobe |
| din | input | 8 | Parallel character, least significant bit sent first |
| txd | output | 1 | Serial line output, idles high |
| buf_empty | output | 1 | Holding register can take a new character |
| tx_empty | output | 1 | Nothing queued or being sent, and the reset settling period is over |

## Verification
The assertions check on every cycle that the line stays quiet and `tx_empty` stays low through the reset settling period. They also check that a load rising edge empties nothing and marks the holding register full, that `tx_empty` can only fall together with a low start bit, that the line holds steady inside a bit cell, and that an idle transmitter leaves the line high. Only the bench scenarios can show the full content of each frame: bit order, masking of the upper data bits, parity polarity, the exact stop length for each combination of length and stop select, back-to-back chaining with no gap, and the hold behaviour of the control register. The bench checks these by decoding the serial line at the centre of each bit and comparing the result against a queue of expected characters.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
   // Frame format held by the control register.
   typedef struct packed {
      logic [1:0] len_sel;
      logic       stop_sel;
      logic       par_off;
      logic       par_even;
   } ftx_ctl_t;
endpackage

// File: rtl/ftx_ctrl_reg.sv
module ftx_ctrl_reg
   import ftx_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     cfg_load,
   input  ftx_ctl_t ctl_in,
   output ftx_ctl_t ctl_q
);
   // Transparent while cfg_load is high; the last value is kept once it drops.
   always_ff @(posedge clk) begin
      if (rst)
         ctl_q <= '0;
      else if (cfg_load)
         ctl_q <= ctl_in;
   end
endmodule

// File: rtl/ftx_holding.sv
module ftx_holding #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_n,
   input  logic [DATA_W-1:0] din,
   input  logic              take,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q
);
   logic load_prev;
   logic load_rise;

   assign load_rise = load_n & ~load_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         load_prev <= 1'b1;
         full_q    <= 1'b0;
         data_q    <= '0;
      end else begin
         load_prev <= load_n;
         if (!load_n)
            data_q <= din;
         if (load_rise)
            full_q <= 1'b1;
         else if (take)
            full_q <= 1'b0;
      end
   end

   // A completed load strobe must leave the register marked full.
   AST_LOAD_MARKS_FULL: assert property (@(posedge clk) disable iff (rst)
      load_rise |=> full_q) else $error("load rise did not mark full"); // R2
endmodule

// File: rtl/ftx_serializer.sv
module ftx_serializer
   import ftx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MIN_LEN = 5,
   parameter int OSR     = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              pend,
   input  logic [DATA_W-1:0] bdata,
   input  ftx_ctl_t          ctl,
   output logic              take,
   output logic              busy,
   output logic              txd
);
   localparam int FRAME_W  = DATA_W + 2;
   localparam int TICK_W   = $clog2(OSR);
   localparam int STOP_MAX = 2 * OSR;
   localparam int STOP_W   = $clog2(STOP_MAX + 1);
   localparam int BIT_W    = $clog2(FRAME_W + 1);
   localparam logic [STOP_W-1:0] STOP_ONE  = STOP_W'(OSR);
   localparam logic [STOP_W-1:0] STOP_HALF = STOP_W'(OSR + OSR / 2);
   localparam logic [STOP_W-1:0] STOP_TWO  = STOP_W'(STOP_MAX);

   logic [BIT_W-1:0]   len;
   logic [DATA_W-1:0]  masked;
   logic               par_bit;
   logic [FRAME_W-1:0] frame_vec;
   logic [BIT_W-1:0]   body_n;
   logic [STOP_W-1:0]  stop_n;

   logic [FRAME_W-1:0] sr;
   logic [BIT_W-1:0]   bits_left;
   logic [TICK_W-1:0]  tick_cnt;
   logic [STOP_W-1:0]  stop_left;
   logic [STOP_W-1:0]  stop_len_q;
   logic               in_stop;
   logic               frame_end;

   assign len = BIT_W'(MIN_LEN) + BIT_W'(ctl.len_sel);

   // Drop data bits above the selected length.
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign masked[i] = bdata[i] & (BIT_W'(i) < len);
   end

   assign par_bit = ctl.par_even ? ^masked : ~^masked;
   assign body_n  = len + BIT_W'(1) + BIT_W'(!ctl.par_off);

   always_comb begin
      frame_vec            = '0;
      frame_vec[DATA_W:1]  = masked;
      for (int i = 1; i < FRAME_W; i++) begin
         if (!ctl.par_off && BIT_W'(i) == len + BIT_W'(1))
            frame_vec[i] = par_bit;
      end
   end

   always_comb begin
      if (!ctl.stop_sel)
         stop_n = STOP_ONE;
      else if (ctl.len_sel == 2'd0)
         stop_n = STOP_HALF;
      else
         stop_n = STOP_TWO;
   end

   assign frame_end = busy && in_stop && stop_left == STOP_W'(1);
   assign take      = pend && enable && (!busy || frame_end);
   assign txd       = !busy || in_stop || sr[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         busy       <= 1'b0;
         in_stop    <= 1'b0;
         sr         <= '1;
         bits_left  <= '0;
         tick_cnt   <= '0;
         stop_left  <= '0;
         stop_len_q <= '0;
      end else if (take) begin
         busy       <= 1'b1;
         in_stop    <= 1'b0;
         sr         <= frame_vec;
         bits_left  <= body_n;
         tick_cnt   <= '0;
         stop_len_q <= stop_n;
      end else if (busy) begin
         if (!in_stop) begin
            tick_cnt <= (tick_cnt == TICK_W'(OSR - 1)) ? '0 : tick_cnt + TICK_W'(1);
            if (tick_cnt == TICK_W'(OSR - 1)) begin
               if (bits_left == BIT_W'(1)) begin
                  in_stop   <= 1'b1;
                  stop_left <= stop_len_q;
               end else begin
                  sr        <= {1'b1, sr[FRAME_W-1:1]};
                  bits_left <= bits_left - BIT_W'(1);
               end
            end
         end else if (stop_left == STOP_W'(1)) begin
            busy    <= 1'b0;
            in_stop <= 1'b0;
         end else begin
            stop_left <= stop_left - STOP_W'(1);
         end
      end
   end

   // Inside a frame body the line may only move on a bit-cell boundary.
   AST_BIT_STABLE: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && !$past(in_stop) && !in_stop &&
       $past(tick_cnt) != TICK_W'(OSR - 1)) |-> $stable(txd))
      else $error("line moved inside a bit cell"); // R4
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
   import ftx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int MIN_LEN    = 5,
   parameter int OSR        = 16,
   parameter int RST_SETTLE = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_load,
   input  logic [1:0]        len_sel,
   input  logic              stop_sel,
   input  logic              par_off,
   input  logic              par_even,
   input  logic              load_n,
   input  logic [DATA_W-1:0] din,
   output logic              txd,
   output logic              buf_empty,
   output logic              tx_empty
);
   localparam int SET_W = $clog2(RST_SETTLE + 1);

   if (OSR < 2 || (OSR % 2) != 0) begin : g_bad_osr
      $error("OSR must be even and at least 2");
   end
   if (DATA_W < MIN_LEN || DATA_W - MIN_LEN > 3) begin : g_bad_len
      $error("DATA_W must cover four lengths starting at MIN_LEN");
   end
   if (RST_SETTLE < 1) begin : g_bad_settle
      $error("RST_SETTLE must be at least 1");
   end

   ftx_ctl_t          ctl_in;
   ftx_ctl_t          ctl_q;
   logic [DATA_W-1:0] hold_data;
   logic              hold_full;
   logic              take;
   logic              busy;
   logic [SET_W-1:0]  settle_cnt;
   logic              settled;

   assign ctl_in = '{len_sel: len_sel, stop_sel: stop_sel,
                     par_off: par_off, par_even: par_even};

   always_ff @(posedge clk) begin
      if (rst)
         settle_cnt <= SET_W'(RST_SETTLE);
      else if (settle_cnt != '0)
         settle_cnt <= settle_cnt - SET_W'(1);
   end
   assign settled = (settle_cnt == '0);

   ftx_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .cfg_load (cfg_load),
      .ctl_in   (ctl_in),
      .ctl_q    (ctl_q)
   );

   ftx_holding #(.DATA_W(DATA_W)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .load_n (load_n),
      .din    (din),
      .take   (take),
      .data_q (hold_data),
      .full_q (hold_full)
   );

   ftx_serializer #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .OSR(OSR)) u_ser (
      .clk    (clk),
      .rst    (rst),
      .enable (settled),
      .pend   (hold_full),
      .bdata  (hold_data),
      .ctl    (ctl_q),
      .take   (take),
      .busy   (busy),
      .txd    (txd)
   );

   assign buf_empty = ~hold_full;
   assign tx_empty  = settled & ~busy;

   AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !settled |-> (!tx_empty && txd)) else $error("activity during settle"); // R1
   AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
      $fell(tx_empty) |-> !txd) else $error("frame began without start bit"); // R3
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      tx_empty |-> txd) else $error("idle line not high"); // R9
endmodule

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int  nbits;
      int  data;
      bit  has_par;
      bit  par;
      int  stop;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_load = 1'b1;
   logic [1:0] len_sel = 2'd3;
   logic       stop_sel = 1'b0;
   logic       par_off = 1'b1;
   logic       par_even = 1'b0;
   logic       load_n = 1'b1;
   logic [7:0] din = 8'h00;
   logic       txd, buf_empty, tx_empty;

   int n_vec = 0;
   int n_bad = 0;
   exp_t exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   serial_frame_tx uut (
      .clk(clk), .rst(rst), .cfg_load(cfg_load), .len_sel(len_sel),
      .stop_sel(stop_sel), .par_off(par_off), .par_even(par_even),
      .load_n(load_n), .din(din), .txd(txd), .buf_empty(buf_empty),
      .tx_empty(tx_empty)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic exp_t make_exp(input int d, input int ls, input bit ss,
                                     input bit pi, input bit pe);
      exp_t e;
      e.nbits   = 5 + ls;
      e.data    = d & ((1 << e.nbits) - 1);
      e.has_par = !pi;
      e.par     = pe ? ^e.data[7:0] : ~^e.data[7:0];
      e.stop    = !ss ? 16 : (ls == 0 ? 24 : 32);
      return e;
   endfunction

   // Queue a character; waits for a free holding register first.
   task automatic send(input int d, input int ls, input bit ss, input bit pi,
                       input bit pe, input bit drive_cfg);
      while (!buf_empty) @(negedge clk);
      if (drive_cfg) begin
         cfg_load = 1'b1; len_sel = 2'(ls); stop_sel = ss;
         par_off = pi; par_even = pe;
         @(negedge clk);
      end
      exp_q.push_back(make_exp(d, ls, ss, pi, pe));
      din = 8'(d); load_n = 1'b0;
      @(negedge clk);
      load_n = 1'b1; din = 8'h00;
      @(negedge clk);
   endtask

   task automatic wait_idle();
      while (!(tx_empty && buf_empty && exp_q.size() == 0)) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // Monitor: decode the line at bit centres and compare with the queue.
   initial begin
      @(negedge clk);
      forever begin
         while (!(txd === 1'b0 && !rst)) @(negedge clk);
         begin
            exp_t e;
            int   got;
            int   cnt;
            bit   pb;
            repeat (7) @(negedge clk);
            chk(txd === 1'b0, "R3 start bit", int'(txd), 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected frame", 1, 0);
               e = make_exp(0, 3, 0, 1, 0);
            end else begin
               e = exp_q.pop_front();
            end
            got = 0;
            for (int j = 0; j < e.nbits; j++) begin
               repeat (16) @(negedge clk);
               if (txd) got |= (1 << j);
            end
            chk(got == e.data, "R4/R5 data bits", got, e.data);
            if (e.has_par) begin
               repeat (16) @(negedge clk);
               pb = txd;
               chk(pb == e.par, "R6 parity bit", int'(pb), int'(e.par));
            end
            repeat (9) @(negedge clk);
            cnt = 0;
            while (txd === 1'b1 && !tx_empty) begin
               cnt++;
               @(negedge clk);
            end
            chk(cnt == e.stop, "R7/R8/R9 stop length", cnt, e.stop);
         end
      end
   end

   // Watchdog
   initial begin
      #(CLK_PERIOD * 150000);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state and settling period; a load during settling waits.
      repeat (3) @(negedge clk);
      chk(buf_empty === 1'b1, "R1 buf_empty in reset", int'(buf_empty), 1);
      chk(tx_empty === 1'b0, "R1 tx_empty in reset", int'(tx_empty), 0);
      chk(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
      rst = 1'b0;
      for (int i = 1; i <= 17; i++) begin
         @(negedge clk);
         chk(tx_empty === 1'b0 && txd === 1'b1, "R1 settle quiet", int'(tx_empty), 0);
      end
      @(negedge clk);
      chk(tx_empty === 1'b1, "R1 tx_empty after 18 clocks", int'(tx_empty), 1);

      // R2/R3: load strobe timing with the shifter idle; 8 bits, no parity, 1 stop.
      exp_q.push_back(make_exp(8'hA5, 3, 0, 1, 0));
      din = 8'hA5; load_n = 1'b0;
      @(negedge clk);
      chk(buf_empty === 1'b1, "R2 low level keeps buf_empty", int'(buf_empty), 1);
      load_n = 1'b1; din = 8'h00;
      @(negedge clk);
      chk(buf_empty === 1'b0, "R2 rise clears buf_empty", int'(buf_empty), 0);
      chk(tx_empty === 1'b1, "R3 before transfer", int'(tx_empty), 1);
      @(negedge clk);
      chk(buf_empty === 1'b1, "R3 buf_empty after transfer", int'(buf_empty), 1);
      chk(tx_empty === 1'b0, "R3 tx_empty after transfer", int'(tx_empty), 0);
      chk(txd === 1'b0, "R3 start bit out", int'(txd), 0);
      wait_idle();
      chk(txd === 1'b1, "R4 idle line high", int'(txd), 1);

      // R5/R6: lengths and parity variants, upper bits must be masked.
      send(8'hE3, 0, 0, 0, 1, 1);   // 5 bits even parity: upper ones ignored
      wait_idle();
      send(8'hC6, 1, 0, 0, 0, 1);   // 6 bits odd parity
      wait_idle();
      send(8'h9B, 2, 0, 0, 1, 1);   // 7 bits even parity
      wait_idle();
      send(8'h7E, 3, 0, 0, 0, 1);   // 8 bits odd parity
      wait_idle();

      // R7: long stop periods.
      send(8'h15, 0, 1, 1, 0, 1);   // 1.5 stop
      wait_idle();
      send(8'h2C, 1, 1, 0, 1, 1);   // 2 stop
      wait_idle();
      send(8'h81, 3, 1, 0, 0, 1);   // 2 stop, 8 bits
      wait_idle();

      // R8: chaining, second character waits and follows with no gap.
      send(8'h55, 3, 0, 1, 0, 1);
      send(8'h0F, 0, 1, 0, 0, 1);
      repeat (3) @(negedge clk);
      chk(buf_empty === 1'b0, "R8 queued char waits", int'(buf_empty), 0);
      send(8'hF0, 2, 1, 0, 1, 1);
      send(8'h33, 3, 1, 1, 0, 1);
      wait_idle();

      // R10: control held while cfg_load low.
      cfg_load = 1'b1; len_sel = 2'd1; stop_sel = 1'b1; par_off = 1'b0; par_even = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      len_sel = 2'd3; stop_sel = 1'b0; par_off = 1'b1; par_even = 1'b0;
      @(negedge clk);
      send(8'hFA, 1, 1, 0, 1, 0);   // expected with the held format
      wait_idle();
      cfg_load = 1'b1;
      @(negedge clk);
      send(8'h6D, 3, 0, 1, 0, 0);   // now follows the pins again
      wait_idle();

      // R1: a load during settling waits for the settle period to end.
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      exp_q.push_back(make_exp(8'h3C, 3, 0, 1, 0));
      din = 8'h3C; load_n = 1'b0;
      @(negedge clk);
      load_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(txd === 1'b1 && buf_empty === 1'b0, "R1 load held during settle", int'(txd), 1);
      wait_idle();

      chk(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule